// File: doc/BRIEF.md
# Key-Locked Watchdog Countdown Timer

This block is a memory-mapped watchdog. A 32-bit down-counter advances once for each pulse on a count-enable strobe. When it runs out, the block records the expiry in a status register. Depending on two enable bits, it also requests a system reset for one cycle and raises an interrupt. Software feeds the watchdog by loading a fresh count before it runs out.

The count and enable registers are protected by a key. A write to either one takes effect only after the exact 32-bit value 0x0000482E has been written to the key register. Any other value written to the key register locks them again. The status register is not protected: its two flags are cleared by writing 1 to them.

The block has two resets:
- An asynchronous power-on reset clears everything.
- A synchronous warm reset returns the block to idle but keeps the flag that marks a reset caused by the watchdog. After a restart, software can read that flag to learn why the chip reset.

Top module: `wdt_top`

## Requirements
- R1: After power-on reset, every register reads 0, and `rst_req` and `irq` are 0.
- R2: Writing exactly 0x0000482E to the key register (byte offset 0x1C) unlocks the block, and the key register then reads 1. Writing any other 32-bit value locks it, and the key register then reads 0.
- R3: While the block is locked, writes to the count register (0x14) and the enable register (0x18) have no effect.
- R4: While unlocked, the enable register (0x18) stores write-data bits [2:0] and reads them back. Bit 0 is reset enable, bit 1 is interrupt enable and bit 2 is count enable. The count register (0x14) reads back its current value.
- R5: With count enable set, each cycle with `tick` high lowers a nonzero count by one. Without `tick`, the count does not change.
- R6: Expiry happens on a counting tick while the count is 1, or while a freshly loaded count is 0. On that clock edge the count becomes 0 and status bit 3 (pending) at offset 0x20 is set.
- R7: If reset enable is set at expiry, `rst_req` goes high for exactly one cycle after that edge and status bit 4 (warm flag) is set. If reset enable is clear, there is no pulse and bit 4 is unchanged.
- R8: `irq` is high while status bit 3 is set and interrupt enable is set.
- R9: Writing 1 to status bit 3 or bit 4 clears that bit. Writing 0 leaves it as it is. An expiry on the same edge wins over the clear.
- R10: After expiry the count holds at 0 and does not expire again. Writing the count register restarts the countdown from the new value (keepalive).
- R11: A warm reset clears the count, the enable bits, the lock state and status bit 3. Status bit 4 survives it. Only power-on reset clears bit 4.
- R12: Writing 0 to the enable register while unlocked stops counting: the count no longer changes on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset; keeps the warm flag |
| tick | input | 1 | Count-clock enable strobe |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions check on every cycle the properties that hold at each clock edge:
- the reset request lasts only one cycle and always comes with the warm flag;
- an expiry always sets the pending flag, and raises the interrupt when interrupt enable is set;
- a counting tick lowers a nonzero count by exactly one;
- a zero count holds until it is reloaded;
- the enable bits do not change while the block is locked;
- a warm reset leaves the block idle.

Only the bench scenarios can show the behaviours that need whole register sequences:
- the full-word key compare;
- the programming order;
- write-1-to-clear;
- a keepalive reload pushing back the expiry;
- the warm flag surviving a warm reset but not a power-on reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned CNT_W = 32;

  localparam int unsigned OFS_COUNT  = 'h14;
  localparam int unsigned OFS_ENABLE = 'h18;
  localparam int unsigned OFS_KEY    = 'h1C;
  localparam int unsigned OFS_STATUS = 'h20;

  localparam int unsigned PEND_BIT = 3;
  localparam int unsigned WARM_BIT = 4;

  typedef struct packed {
    logic cnt_on;  // bit 2
    logic irq_on;  // bit 1
    logic rst_on;  // bit 0
  } wdt_en_t;

  // A tick at count 1, or at a fresh zero, is the expiry event.
  function automatic logic expiry_hit(input logic [CNT_W-1:0] c, input logic fired);
    return !fired && (c <= CNT_W'(1));
  endfunction

  // Down-step that saturates at zero.
  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - CNT_W'(1);
  endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             warm_rst,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic fired;

  assign expire = run && !load && !warm_rst && expiry_hit(cnt, fired);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (warm_rst) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (load) begin
      cnt   <= load_val;
      fired <= 1'b0;
    end else if (run) begin
      cnt <= count_step(cnt);
      if (expire) fired <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       warm_rst,
  input  logic       expire,
  input  logic       rst_on,
  input  logic       clr_wr,
  input  logic [1:0] clr_mask,  // [0] pending, [1] warm flag
  output logic       pend,
  output logic       warm,
  output logic       rst_req
);
  logic rst_fire;
  assign rst_fire = expire && rst_on;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pend    <= 1'b0;
      warm    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= rst_fire && !warm_rst;
      if (warm_rst)                    pend <= 1'b0;
      else if (expire)                 pend <= 1'b1;
      else if (clr_wr && clr_mask[0])  pend <= 1'b0;
      // The warm flag lives outside the warm-reset domain.
      if (rst_fire)                    warm <= 1'b1;
      else if (clr_wr && clr_mask[1])  warm <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [15:0] KEY_VAL = 16'h482E
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              pend,
  input  logic              warm,
  output logic              unlocked,
  output wdt_en_t           en,
  output logic              load,
  output logic              wr_en_evt,
  output logic              clr_wr,
  output logic [CNT_W-1:0]  rdata
);
  localparam logic [CNT_W-1:0] KEY_WORD = CNT_W'(KEY_VAL);

  logic hit_cnt, hit_en, hit_key, hit_sts;
  assign hit_cnt = (addr == ADDR_W'(OFS_COUNT));
  assign hit_en  = (addr == ADDR_W'(OFS_ENABLE));
  assign hit_key = (addr == ADDR_W'(OFS_KEY));
  assign hit_sts = (addr == ADDR_W'(OFS_STATUS));

  assign load      = we && hit_cnt && unlocked;
  assign wr_en_evt = we && hit_en && unlocked;
  assign clr_wr    = we && hit_sts;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      unlocked <= 1'b0;
      en       <= '0;
    end else if (warm_rst) begin
      unlocked <= 1'b0;
      en       <= '0;
    end else begin
      if (we && hit_key) unlocked <= (wdata == KEY_WORD);
      if (wr_en_evt)     en <= wdt_en_t'(wdata[2:0]);
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_cnt) rdata = cnt;
    if (hit_en)  rdata = CNT_W'(en);
    if (hit_key) rdata = CNT_W'(unlocked);
    if (hit_sts) begin
      rdata[PEND_BIT] = pend;
      rdata[WARM_BIT] = warm;
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [15:0] KEY_VAL = 16'h482E
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              rst_req,
  output logic              irq
);
  // Named internal events, visible to the bound checker.
  logic             unlocked, load, wr_en_evt, clr_wr, expire, pend, warm, run;
  logic [CNT_W-1:0] cnt;
  wdt_en_t          en;

  assign run = tick && en.cnt_on;
  assign irq = pend && en.irq_on;

  wdt_regif #(.ADDR_W(ADDR_W), .KEY_VAL(KEY_VAL)) regif_i (
    .clk(clk), .por_n(por_n), .warm_rst(warm_rst),
    .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .cnt(cnt), .pend(pend), .warm(warm),
    .unlocked(unlocked), .en(en), .load(load), .wr_en_evt(wr_en_evt),
    .clr_wr(clr_wr), .rdata(bus_rdata)
  );

  wdt_counter counter_i (
    .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .run(run),
    .load(load), .load_val(bus_wdata), .cnt(cnt), .expire(expire)
  );

  wdt_status status_i (
    .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .expire(expire),
    .rst_on(en.rst_on), .clr_wr(clr_wr),
    .clr_mask(bus_wdata[WARM_BIT:PEND_BIT]),
    .pend(pend), .warm(warm), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
(
  input logic             clk,
  input logic             por_n,
  input logic             warm_rst,
  input logic             tick,
  input logic             rst_req,
  input logic             irq,
  input logic             unlocked,
  input logic [2:0]       en_bits,
  input logic [CNT_W-1:0] cnt,
  input logic             expire,
  input logic             load,
  input logic             wr_en_evt,
  input logic             pend,
  input logic             warm
);
  assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> !rst_req);

  assert_warm_with_rst_R7: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> warm);

  assert_pend_on_expiry_R6: assert property (@(posedge clk) disable iff (!por_n)
    expire |=> pend);

  assert_irq_on_expiry_R8: assert property (@(posedge clk) disable iff (!por_n)
    (expire && en_bits[1] && !wr_en_evt) |=> irq);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!por_n)
    (tick && en_bits[2] && !load && !warm_rst && cnt != '0)
      |=> cnt == $past(cnt) - CNT_W'(1));

  assert_hold_zero_R10: assert property (@(posedge clk) disable iff (!por_n)
    (cnt == '0 && !load) |=> cnt == '0);

  assert_locked_enable_R3: assert property (@(posedge clk) disable iff (!por_n)
    (!unlocked && !warm_rst) |=> $stable(en_bits));

  assert_warm_idle_R11: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst |=> (!unlocked && en_bits == 3'b0 && cnt == '0 && !pend));
endmodule

bind wdt_top wdt_chk chk_i (
  .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .tick(tick),
  .rst_req(rst_req), .irq(irq), .unlocked(unlocked), .en_bits(en),
  .cnt(cnt), .expire(expire), .load(load), .wr_en_evt(wr_en_evt),
  .pend(pend), .warm(warm)
);

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
  localparam logic [7:0]  A_CNT = 8'h14, A_EN = 8'h18, A_KEY = 8'h1C, A_STS = 8'h20;
  localparam logic [31:0] KEY   = 32'h0000482E;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_top dut_i (
    .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .tick(tick),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 chk(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic power_on();
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
  endtask

  task automatic arm(input logic [31:0] count, input logic [2:0] enb);
    wr(A_KEY, KEY); wr(A_EN, 32'h0); wr(A_CNT, count); wr(A_EN, {29'h0, enb});
  endtask

  task automatic t_reset();
    chk("R1 rst_req", {31'h0, rst_req}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd_chk("R1 count", A_CNT, 32'h0);
    rd_chk("R1 enable", A_EN, 32'h0);
    rd_chk("R1 key", A_KEY, 32'h0);
    rd_chk("R1 status", A_STS, 32'h0);
  endtask

  task automatic t_key_lock();
    wr(A_KEY, KEY);          rd_chk("R2 unlock", A_KEY, 32'h1);
    wr(A_CNT, 32'h1234);     rd_chk("R4 count readback", A_CNT, 32'h1234);
    wr(A_EN, 32'hFFFF_FFF2); rd_chk("R4 enable bits", A_EN, 32'h2);
    wr(A_KEY, 32'h1234_482E); rd_chk("R2 relock wide", A_KEY, 32'h0);
    wr(A_CNT, 32'h55);       rd_chk("R3 locked count", A_CNT, 32'h1234);
    wr(A_EN, 32'h5);         rd_chk("R3 locked enable", A_EN, 32'h2);
    wr(A_KEY, KEY); wr(A_KEY, 32'h0); rd_chk("R2 relock zero", A_KEY, 32'h0);
  endtask

  task automatic t_count_stop();
    arm(32'd10, 3'b100);
    ticks(3);                rd_chk("R5 decrement", A_CNT, 32'd7);
    repeat (3) @(negedge clk);
    rd_chk("R5 no tick", A_CNT, 32'd7);
    wr(A_EN, 32'h0);
    ticks(3);                rd_chk("R12 stopped", A_CNT, 32'd7);
  endtask

  task automatic t_expiry_reset();
    arm(32'd3, 3'b111);
    wr(A_KEY, 32'h0);
    ticks(2);                rd_chk("R5 count 1", A_CNT, 32'd1);
    ticks(1);
    chk("R7 rst pulse", {31'h0, rst_req}, 32'h1);
    chk("R8 irq", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'h0, rst_req}, 32'h0);
    rd_chk("R6 status set", A_STS, 32'h18);
    rd_chk("R6 count zero", A_CNT, 32'h0);
    ticks(5);
    chk("R10 no refire", {31'h0, rst_req}, 32'h0);
    rd_chk("R10 hold zero", A_CNT, 32'h0);
    wr(A_STS, 32'h0);        rd_chk("R9 write 0 keeps", A_STS, 32'h18);
    wr(A_STS, 32'h08);       rd_chk("R9 clear pend", A_STS, 32'h10);
    chk("R8 irq drops", {31'h0, irq}, 32'h0);
    ticks(3);                rd_chk("R10 no second expiry", A_STS, 32'h10);
  endtask

  task automatic t_keepalive();
    wr(A_KEY, KEY); wr(A_CNT, 32'd4);
    ticks(2);                rd_chk("R10 partial", A_CNT, 32'd2);
    wr(A_CNT, 32'd4);        rd_chk("R10 reload", A_CNT, 32'd4);
    ticks(3);
    chk("R10 not yet", {31'h0, rst_req}, 32'h0);
    ticks(1);
    chk("R10 expires after reload", {31'h0, rst_req}, 32'h1);
    wr(A_STS, 32'h18);       rd_chk("R9 clear both", A_STS, 32'h0);
  endtask

  task automatic t_no_reset_en();
    arm(32'd2, 3'b100);
    ticks(2);
    chk("R7 no pulse", {31'h0, rst_req}, 32'h0);
    chk("R8 irq off", {31'h0, irq}, 32'h0);
    rd_chk("R7 warm clear", A_STS, 32'h08);
    wr(A_STS, 32'h08);
    arm(32'd0, 3'b101);
    ticks(1);
    chk("R6 zero load expires", {31'h0, rst_req}, 32'h1);
  endtask

  task automatic t_warm();
    rd_chk("R7 warm set", A_STS, 32'h18);
    wr(A_CNT, 32'd9);
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    rd_chk("R11 warm kept", A_STS, 32'h10);
    rd_chk("R11 count", A_CNT, 32'h0);
    rd_chk("R11 enable", A_EN, 32'h0);
    rd_chk("R11 key", A_KEY, 32'h0);
    power_on();
    rd_chk("R11 por clears warm", A_STS, 32'h0);
  endtask

  initial begin
    power_on();
    t_reset();
    t_key_lock();
    t_count_stop();
    t_expiry_reset();
    t_keepalive();
    t_no_reset_en();
    t_warm();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog timeout got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule